// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between a processor's load/store stage and a 32-bit data memory that numbers its bytes big-endian: the byte at address offset 0 is carried on bits 31:24 of the memory word, and offset 3 on bits 7:0. A request names its direction, its size (byte, halfword or word), whether a byte load is unsigned, the byte address and the store data. The request is captured in a register. One cycle later the block issues a single word-aligned memory access.

For stores, the block places the low-order bits of the source register on the lanes that the address selects and raises a byte-write enable for those lanes only. For loads, it waits for the memory's read-valid. It then picks the addressed byte or halfword out of the returned word and sign- or zero-extends it to 32 bits. The result appears as a one-cycle response pulse in the cycle after the memory responds. An access that does not fit its natural alignment is never split. It is reported as misaligned with no memory access at all.

The control is a four-state machine. IDLE accepts a request (transition *accept*). ISSUE drives the memory access. From ISSUE, the *to_wait* transition is taken for an aligned load, and the *to_resp* transition is taken for a store or a misaligned access. WAIT holds until read-valid (transition *data_in*). RESP emits the response pulse and returns to IDLE (transition *retire*).

Top module: `lsu_lane_aligner`

## Requirements
- R1: After reset, req_ready is 1 and mem_req and resp_valid are 0.
- R2: A byte load with req_unsigned=0 (size code 2'b00) returns the byte at offset k, taken from memory bits [31-8k:24-8k]. That byte's bit 7 is copied into result bits 31:8.
- R3: A byte load with req_unsigned=1 returns the addressed byte with result bits 31:8 cleared.
- R4: A halfword load (size code 2'b01) at offset 0 returns memory bits 31:16, and at offset 2 returns bits 15:0. The lower address supplies the upper byte. The result is always sign-extended, whatever req_unsigned says.
- R5: A word load (size code 2'b10) at offset 0 returns the whole memory word unchanged.
- R6: A byte store puts source bits 7:0 on every lane. mem_be has exactly one bit set, at bit 3-k for offset k (bit 3 enables bits 31:24).
- R7: A halfword store puts source bits 15:0 on both halves. mem_be is 4'b1100 at offset 0 and 4'b0011 at offset 2.
- R8: A word store writes all 32 source bits with mem_be 4'b1111. mem_be is 0 whenever no write is being issued.
- R9: Three cases are misaligned: a halfword at an odd offset, a word at a nonzero offset, and any access with size code 2'b11. A misaligned access issues no memory request and no write. It answers with resp_valid, resp_misalign=1 and resp_rdata=0 two cycles after acceptance.
- R10: An accepted aligned request drives mem_req for exactly one cycle, in the cycle after acceptance. mem_addr carries the request address with bits 1:0 cleared. req_ready stays 0 from acceptance until the response.
- R11: In a load, mem_rvalid is sampled only after the issue cycle. A read-valid during the issue cycle is ignored. resp_valid is a one-cycle pulse in the cycle after the accepted read-valid.
- R12: An aligned store answers with a resp_valid pulse in the cycle after its issue cycle, with resp_misalign=0 and resp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_unsigned | input | 1 | Zero-extend a byte load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store source register |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read word |
| resp_valid | output | 1 | Response pulse |
| resp_rdata | output | 32 | Extended load result |
| resp_misalign | output | 1 | Access was rejected as misaligned |

## Verification
The hardest case to reach is a read-valid that arrives while the machine is still in ISSUE. A memory that answers too early must not be captured. To reach it, the bench drives mem_rvalid with a decoy word in the very cycle it observes mem_req. It then delays the true reply by several WAIT cycles and checks that only the later word comes back. Misaligned stores are also driven with nonzero store data, to show that no strobe or enable leaks out.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } lsu_state_e;

    typedef struct packed {
        logic      store;
        acc_size_e size;
        logic      uns;
    } acc_ctl_t;

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
    import lsu_lane_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic             misaligned
);
    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = off[0];
            SZ_WORD: misaligned = (off != '0);
            default: misaligned = 1'b1;
        endcase
    end
endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NLANE = DATA_W / 8,
    localparam int OFF_W = $clog2(NLANE)
) (
    input  acc_size_e         size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] lane_data,
    output logic [NLANE-1:0]  lane_be
);
    for (genvar j = 0; j < NLANE; j++) begin : g_lane
        localparam int O = NLANE - 1 - j;
        logic [7:0] half_part;
        if ((O % 2) == 0) begin : g_hi
            assign half_part = src[15:8];
        end else begin : g_lo
            assign half_part = src[7:0];
        end

        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    lane_data[8*j +: 8] = src[7:0];
                    lane_be[j]          = (off == OFF_W'(O));
                end
                SZ_HALF: begin
                    lane_data[8*j +: 8] = half_part;
                    lane_be[j]          = ((off >> 1) == OFF_W'(O / 2));
                end
                SZ_WORD: begin
                    lane_data[8*j +: 8] = src[8*j +: 8];
                    lane_be[j]          = 1'b1;
                end
                default: begin
                    lane_data[8*j +: 8] = 8'h00;
                    lane_be[j]          = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_lane_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NLANE = DATA_W / 8,
    localparam int OFF_W = $clog2(NLANE)
) (
    input  acc_size_e         size,
    input  logic              uns,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] result
);
    logic [7:0]  lane_b [NLANE];
    logic [7:0]  pick_b;
    logic [15:0] pick_h;
    logic [OFF_W-1:0] hi_off;
    logic [OFF_W-1:0] lo_off;

    for (genvar o = 0; o < NLANE; o++) begin : g_split
        assign lane_b[o] = word[DATA_W-1-8*o -: 8];
    end

    assign hi_off = {off[OFF_W-1:1], 1'b0};
    assign lo_off = {off[OFF_W-1:1], 1'b1};
    assign pick_b = lane_b[off];
    assign pick_h = {lane_b[hi_off], lane_b[lo_off]};

    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){pick_b[7] & ~uns}}, pick_b};
            SZ_HALF: result = {{(DATA_W-16){pick_h[15]}}, pick_h};
            SZ_WORD: result = word;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/lsu_lane_aligner.sv
module lsu_lane_aligner
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_store,
    input  logic [1:0]            req_size,
    input  logic                  req_unsigned,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W/8-1:0]   mem_be,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic                  mem_rvalid,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  resp_valid,
    output logic [DATA_W-1:0]     resp_rdata,
    output logic                  resp_misalign
);
    localparam int NLANE = DATA_W / 8;
    localparam int OFF_W = $clog2(NLANE);

    lsu_state_e        state_q, state_d;
    acc_ctl_t          ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              mis_q;

    logic              accept;
    logic              mis_now;
    logic [OFF_W-1:0]  off_q;
    logic [DATA_W-1:0] packed_data;
    logic [NLANE-1:0]  packed_be;
    logic [DATA_W-1:0] extracted;

    assign off_q  = addr_q[OFF_W-1:0];
    assign accept = req_valid && (state_q == ST_IDLE);

    lsu_align_check #(.OFF_W(OFF_W)) u_align (
        .size       (acc_size_e'(req_size)),
        .off        (req_addr[OFF_W-1:0]),
        .misaligned (mis_now)
    );

    lsu_store_pack #(.DATA_W(DATA_W)) u_pack (
        .size      (ctl_q.size),
        .off       (off_q),
        .src       (wdata_q),
        .lane_data (packed_data),
        .lane_be   (packed_be)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
        .size   (ctl_q.size),
        .uns    (ctl_q.uns),
        .off    (off_q),
        .word   (mem_rdata),
        .result (extracted)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;
            ST_ISSUE: state_d = (mis_q || ctl_q.store) ? ST_RESP : ST_WAIT;
            ST_WAIT:  if (mem_rvalid) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and load result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            mis_q   <= 1'b0;
        end else begin
            if (accept) begin
                ctl_q.store <= req_store;
                ctl_q.size  <= acc_size_e'(req_size);
                ctl_q.uns   <= req_unsigned;
                addr_q      <= req_addr;
                wdata_q     <= req_wdata;
                mis_q       <= mis_now;
                rdata_q     <= '0;
            end
            if (state_q == ST_WAIT && mem_rvalid) rdata_q <= extracted;
        end
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        mem_be        = '0;
        mem_wdata     = '0;
        resp_valid    = 1'b0;
        resp_rdata    = '0;
        resp_misalign = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_ISSUE: begin
                mem_req = !mis_q;
                mem_we  = !mis_q && ctl_q.store;
                if (!mis_q && ctl_q.store) begin
                    mem_be    = packed_be;
                    mem_wdata = packed_data;
                end
            end
            ST_WAIT: ;
            ST_RESP: begin
                resp_valid    = 1'b1;
                resp_rdata    = rdata_q;
                resp_misalign = mis_q;
            end
            default: ;
        endcase
    end

    assign mem_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

endmodule

// File: rtl/lsu_lane_aligner_chk.sv
module lsu_lane_aligner_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                mem_req,
    input logic                mem_we,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W/8-1:0] mem_be,
    input logic                resp_valid,
    input logic                resp_misalign
);
    localparam int NLANE = DATA_W / 8;
    localparam int OFF_W = $clog2(NLANE);

    a_r10_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r10_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R6 R7 R8: lane count matches one of the legal sizes
    a_r8_be_count: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_be) == 1 ||
                                 $countones(mem_be) == 2 ||
                                 $countones(mem_be) == NLANE));

    a_r8_be_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mem_we) |-> (mem_be == '0));

    a_r9_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_misalign) |-> !$past(mem_req));

    a_r12_store_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (resp_valid && !resp_misalign));

endmodule

bind lsu_lane_aligner lsu_lane_aligner_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_be        (mem_be),
    .resp_valid    (resp_valid),
    .resp_misalign (resp_misalign)
);

// File: tb/tb_lsu_lane_aligner.sv
module tb_lsu_lane_aligner;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MEMW = 32'h807F_C312;
    localparam logic [31:0] SRC  = 32'hDEAD_BE5A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_unsigned = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        resp_misalign;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_lane_aligner dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
        .req_wdata(req_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_misalign(resp_misalign)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input bit st, input logic [1:0] sz, input bit uns,
                        input logic [31:0] addr, input logic [31:0] wd);
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = uns;
        req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
        chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 0);
        chk(resp_valid == 1'b0, "R1 resp_valid", 32'(resp_valid), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_load(input string tag, input logic [1:0] sz, input bit uns,
                          input logic [31:0] addr, input int waits, input bit decoy,
                          input logic [31:0] exp);
        send(1'b0, sz, uns, addr, 32'h0);
        chk(mem_req == 1'b1 && mem_we == 1'b0, {tag, " R10 issue read"}, {mem_req, mem_we}, 2'b10);
        chk(mem_addr == {addr[31:2], 2'b00}, {tag, " R10 word addr"}, mem_addr, {addr[31:2], 2'b00});
        chk(req_ready == 1'b0, {tag, " R10 busy"}, 32'(req_ready), 0);
        if (decoy) begin
            mem_rvalid = 1'b1; mem_rdata = 32'h5555_5555;
            @(negedge clk);
            mem_rvalid = 1'b0;
            chk(resp_valid == 1'b0, {tag, " R11 decoy ignored"}, 32'(resp_valid), 0);
        end else begin
            @(negedge clk);
        end
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            chk(resp_valid == 1'b0, {tag, " R11 no early resp"}, 32'(resp_valid), 0);
        end
        mem_rvalid = 1'b1; mem_rdata = MEMW;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 32'hAAAA_AAAA;
        chk(resp_valid == 1'b1 && resp_misalign == 1'b0, {tag, " R11 resp pulse"},
            {resp_valid, resp_misalign}, 2'b10);
        chk(resp_rdata == exp, tag, resp_rdata, exp);
        @(negedge clk);
        chk(resp_valid == 1'b0, {tag, " R11 pulse ends"}, 32'(resp_valid), 0);
    endtask

    task automatic t_store(input string tag, input logic [1:0] sz, input logic [31:0] addr,
                           input logic [3:0] exp_be, input logic [31:0] exp_data);
        send(1'b1, sz, 1'b0, addr, SRC);
        chk(mem_req == 1'b1 && mem_we == 1'b1, {tag, " R10 issue write"}, {mem_req, mem_we}, 2'b11);
        chk(mem_addr == {addr[31:2], 2'b00}, {tag, " R10 word addr"}, mem_addr, {addr[31:2], 2'b00});
        chk(mem_be == exp_be, {tag, " be"}, 32'(mem_be), 32'(exp_be));
        chk(mem_wdata == exp_data, {tag, " data"}, mem_wdata, exp_data);
        @(negedge clk);
        chk(mem_req == 1'b0, {tag, " R10 one issue"}, 32'(mem_req), 0);
        chk(resp_valid == 1'b1 && resp_misalign == 1'b0, {tag, " R12 resp"},
            {resp_valid, resp_misalign}, 2'b10);
        chk(resp_rdata == 32'h0, {tag, " R12 rdata"}, resp_rdata, 0);
        @(negedge clk);
        chk(resp_valid == 1'b0, {tag, " R12 pulse ends"}, 32'(resp_valid), 0);
    endtask

    task automatic t_misalign(input string tag, input bit st, input logic [1:0] sz,
                              input logic [31:0] addr);
        send(st, sz, 1'b0, addr, SRC);
        chk(mem_req == 1'b0 && mem_be == 4'h0, {tag, " R9 no access"}, {mem_req, mem_be}, 0);
        chk(req_ready == 1'b0, {tag, " R10 busy"}, 32'(req_ready), 0);
        @(negedge clk);
        chk(mem_req == 1'b0, {tag, " R9 still no access"}, 32'(mem_req), 0);
        chk(resp_valid == 1'b1 && resp_misalign == 1'b1, {tag, " R9 flagged"},
            {resp_valid, resp_misalign}, 2'b11);
        chk(resp_rdata == 32'h0, {tag, " R9 rdata"}, resp_rdata, 0);
        @(negedge clk);
        chk(resp_valid == 1'b0, {tag, " R9 pulse ends"}, 32'(resp_valid), 0);
    endtask

    initial begin
        t_reset();
        t_load("R2 sbyte off0", 2'b00, 1'b0, 32'h0000_1000, 0, 1'b0, 32'hFFFF_FF80);
        t_load("R2 sbyte off1", 2'b00, 1'b0, 32'h0000_1001, 1, 1'b0, 32'h0000_007F);
        t_load("R2 sbyte off2", 2'b00, 1'b0, 32'h0000_1002, 0, 1'b0, 32'hFFFF_FFC3);
        t_load("R3 ubyte off0", 2'b00, 1'b1, 32'h0000_2000, 0, 1'b0, 32'h0000_0080);
        t_load("R3 ubyte off3", 2'b00, 1'b1, 32'h0000_2003, 2, 1'b0, 32'h0000_0012);
        t_load("R4 half off0", 2'b01, 1'b0, 32'h0000_3000, 0, 1'b0, 32'hFFFF_807F);
        t_load("R4 half off2 uns", 2'b01, 1'b1, 32'h0000_3002, 0, 1'b0, 32'hFFFF_C312);
        t_load("R5 word", 2'b10, 1'b0, 32'hABCD_0004, 0, 1'b0, 32'h807F_C312);
        t_load("R11 decoy+wait", 2'b10, 1'b0, 32'h0000_0008, 3, 1'b1, 32'h807F_C312);
        t_store("R6 byte off1", 2'b00, 32'h0000_4001, 4'b0100, 32'h5A5A_5A5A);
        t_store("R6 byte off3", 2'b00, 32'h0000_4003, 4'b0001, 32'h5A5A_5A5A);
        t_store("R7 half off0", 2'b01, 32'h0000_5000, 4'b1100, 32'hBE5A_BE5A);
        t_store("R7 half off2", 2'b01, 32'h0000_5002, 4'b0011, 32'hBE5A_BE5A);
        t_store("R8 word", 2'b10, 32'h0000_6000, 4'b1111, 32'hDEAD_BE5A);
        t_misalign("R9 load half odd", 1'b0, 2'b01, 32'h0000_7001);
        t_misalign("R9 store half off3", 1'b1, 2'b01, 32'h0000_7003);
        t_misalign("R9 store word off2", 1'b1, 2'b10, 32'h0000_7002);
        t_misalign("R9 load word off1", 1'b0, 2'b10, 32'h0000_7001);
        t_misalign("R9 reserved size", 1'b1, 2'b11, 32'h0000_7000);
        t_load("R2 after misalign", 2'b00, 1'b0, 32'h0000_1003, 0, 1'b0, 32'h0000_0012);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule